// File: doc/BRIEF.md
# Transmit Jabber and Heartbeat Supervisor

This block sits between the MAC transmit enable and the twisted-pair transmit path of a 10 Mb/s PHY. It times every frame, and when a frame outlasts a programmable limit it blocks the transmit enable seen by the line side (the jabber condition). It holds that block until the MAC transmit enable has stayed low without a break for a long idle interval. A sticky status flag records each entry into the jabber condition and clears when software reads it.

After every frame that ends normally in twisted-pair mode, the block waits a short, fixed delay and then drives a fixed-width heartbeat pulse on the collision output. This tells the MAC that the collision path works. A disable bit suppresses the heartbeat, and no heartbeat is generated in the phone-line mode or after a frame that jabber cut off. Real collisions detected elsewhere arrive on one input, which is ORed onto the collision output.

All time intervals are given in microseconds and converted to clock cycles from a reference clock frequency parameter. Defaults: 20 MHz clock, 50 ms transmit limit, 500 ms idle release, 1 us heartbeat delay, 1 us heartbeat width.

The jabber machine has four states. `J_IDLE` goes to `J_XMIT` when transmit enable is high. `J_XMIT` goes back to `J_IDLE` when transmit enable is low, or to `J_HOLD` when the limit is reached with jabber enabled. `J_HOLD` goes to `J_COOL` when transmit enable is low. `J_COOL` goes back to `J_HOLD` when transmit enable is high again, or to `J_IDLE` when the idle count completes.

The heartbeat machine has three states. `S_IDLE` goes to `S_WAIT` on a normal frame end when twisted-pair mode is on and the disable bit is clear. `S_WAIT` goes to `S_PULSE` after the delay. `S_PULSE` goes back to `S_IDLE` after the pulse width.

Top module: `tjs_supervisor`

## Requirements
- R1: Directly after reset, jab_stat_o is 0, tx_en_o equals tx_en_i and col_o equals line_col_i.
- R2: While no jabber condition is active, tx_en_o equals tx_en_i in every cycle.
- R3: With jab_en_i high, a frame whose tx_en_i is sampled high on at most JAB cycles (JAB = clock MHz × JAB_LIMIT_US) is passed whole. If tx_en_i is still high on edge JAB+1 of the frame, tx_en_o is low from that edge until release.
- R4: With jab_en_i low, a frame of any length is never cut.
- R5: Once tx_en_i falls after a jabber entry, tx_en_o stays blocked until tx_en_i has been sampled low on IDLE+1 consecutive edges (IDLE = clock MHz × UNJAB_IDLE_US). After exactly IDLE low edges, a raised tx_en_i is still blocked.
- R6: If tx_en_i rises during the idle countdown, the countdown restarts from zero after the next fall.
- R7: jab_stat_o goes high on the edge where jabber is entered. It stays high until a one-cycle pulse on stat_rd_i clears it.
- R8: After a normal frame end, counting the first edge that samples tx_en_i low as edge 0, col_o is high after edges DLY through DLY+WID-1 (DLY = clock MHz × SQE_DELAY_US, WID = clock MHz × SQE_WIDTH_US) and low otherwise.
- R9: No heartbeat follows a frame that ends while sqe_dis_i is 1 or tp_mode_i is 0.
- R10: No heartbeat follows a frame that jabber cut off.
- R11: col_o is the OR of the heartbeat pulse and line_col_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| jab_en_i | input | 1 | Allows the jabber cut-off when high |
| sqe_dis_i | input | 1 | Suppresses the heartbeat when high |
| tp_mode_i | input | 1 | High when twisted-pair mode is active |
| line_col_i | input | 1 | Collision detected on the line |
| stat_rd_i | input | 1 | Read strobe that clears the jabber status |
| tx_en_o | output | 1 | Gated transmit enable to the line side |
| jab_stat_o | output | 1 | Sticky jabber-entry status |
| col_o | output | 1 | Collision and heartbeat output |

## Verification
A wrong state in the jabber machine shows up at once on tx_en_o when transmit enable is next high: a frame is cut one cycle too early or too late, or a blocked enable comes through before the idle count ends. Because of this, the bench raises transmit enable exactly at the release boundary. Counter mistakes in the heartbeat machine move or stretch the col_o pulse by whole cycles within a few microseconds of the frame end, and they are caught by comparing every cycle of that window. A lost or spurious status bit becomes visible on the first sample after the frame.

// File: rtl/tjs_pkg.sv
package tjs_pkg;

    typedef enum logic [1:0] {
        J_IDLE,
        J_XMIT,
        J_HOLD,
        J_COOL
    } jab_st_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_PULSE
    } sqe_st_t;

    // microsecond interval to clock cycles, never below one
    function automatic int unsigned us_to_cyc(input int unsigned hz, input int unsigned us);
        int unsigned c;
        c = (hz / 1_000_000) * us;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/tjs_timer.sv
module tjs_timer #(
    parameter int unsigned CW    = 8,
    parameter int unsigned SAT_V = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] SAT_C = CW'(SAT_V);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != SAT_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    AST_TIMER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT_C);  // R3
endmodule

// File: rtl/tjs_jabber_fsm.sv
module tjs_jabber_fsm
    import tjs_pkg::*;
#(
    parameter int unsigned JAB_CYC  = 1000,
    parameter int unsigned IDLE_CYC = 10000,
    parameter int unsigned CW       = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic jab_en_i,
    output logic jabbed_o,
    output logic frame_done_o,
    output logic jab_entry_o
);
    localparam int unsigned MAXC = (JAB_CYC > IDLE_CYC) ? JAB_CYC : IDLE_CYC;
    localparam logic [CW-1:0] JAB_LAST  = CW'(JAB_CYC - 1);
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC - 1);

    jab_st_t       st_q, st_d;
    logic [CW-1:0] cnt;
    logic          t_clr, t_run;

    tjs_timer #(.CW(CW), .SAT_V(MAXC - 1)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (t_clr),
        .run_i (t_run),
        .cnt_o (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= J_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            J_IDLE: if (tx_en_i) st_d = J_XMIT;
            J_XMIT: begin
                if (!tx_en_i)                           st_d = J_IDLE;
                else if (jab_en_i && cnt >= JAB_LAST)   st_d = J_HOLD;
            end
            J_HOLD: if (!tx_en_i) st_d = J_COOL;
            J_COOL: begin
                if (tx_en_i)                st_d = J_HOLD;
                else if (cnt >= IDLE_LAST)  st_d = J_IDLE;
            end
            default: st_d = J_IDLE;
        endcase
    end

    always_comb begin
        t_clr        = (st_d != st_q);
        t_run        = (st_q == J_XMIT) || (st_q == J_COOL);
        jabbed_o     = (st_q == J_HOLD) || (st_q == J_COOL);
        frame_done_o = (st_q == J_XMIT) && !tx_en_i;
        jab_entry_o  = (st_q == J_XMIT) && (st_d == J_HOLD);
    end

    AST_JAB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == J_HOLD && $past(st_q) == J_XMIT) |-> ($past(jab_en_i) && $past(tx_en_i)));  // R4
    AST_COOL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == J_COOL) |-> !$past(tx_en_i));  // R5
    AST_COOL_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == J_HOLD && $past(st_q) == J_COOL) |-> $past(tx_en_i));  // R6
endmodule

// File: rtl/tjs_sqe_fsm.sv
module tjs_sqe_fsm
    import tjs_pkg::*;
#(
    parameter int unsigned DLY_CYC = 20,
    parameter int unsigned WID_CYC = 20,
    parameter int unsigned CW      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done_i,
    input  logic tp_mode_i,
    input  logic sqe_dis_i,
    output logic hb_o
);
    localparam int unsigned MAXC = (DLY_CYC > WID_CYC) ? DLY_CYC : WID_CYC;
    localparam logic [CW-1:0] DLY_LAST = CW'(DLY_CYC - 1);
    localparam logic [CW-1:0] WID_LAST = CW'(WID_CYC - 1);

    sqe_st_t       st_q, st_d;
    logic [CW-1:0] cnt;
    logic          t_clr, t_run;

    tjs_timer #(.CW(CW), .SAT_V(MAXC - 1)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (t_clr),
        .run_i (t_run),
        .cnt_o (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (frame_done_i && tp_mode_i && !sqe_dis_i) st_d = S_WAIT;
            S_WAIT:  if (cnt >= DLY_LAST) st_d = S_PULSE;
            S_PULSE: if (cnt >= WID_LAST) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        t_clr = (st_d != st_q);
        t_run = (st_q != S_IDLE);
        hb_o  = (st_q == S_PULSE);
    end

    AST_ARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WAIT && $past(st_q) == S_IDLE) |-> ($past(tp_mode_i) && !$past(sqe_dis_i)));  // R9
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_PULSE) |-> (cnt <= WID_LAST));  // R8
endmodule

// File: rtl/tjs_supervisor.sv
module tjs_supervisor
    import tjs_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 20_000_000,
    parameter int unsigned JAB_LIMIT_US   = 50_000,
    parameter int unsigned UNJAB_IDLE_US  = 500_000,
    parameter int unsigned SQE_DELAY_US   = 1,
    parameter int unsigned SQE_WIDTH_US   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic jab_en_i,
    input  logic sqe_dis_i,
    input  logic tp_mode_i,
    input  logic line_col_i,
    input  logic stat_rd_i,
    output logic tx_en_o,
    output logic jab_stat_o,
    output logic col_o
);
    localparam int unsigned JAB_CYC  = us_to_cyc(CLK_HZ, JAB_LIMIT_US);
    localparam int unsigned IDLE_CYC = us_to_cyc(CLK_HZ, UNJAB_IDLE_US);
    localparam int unsigned DLY_CYC  = us_to_cyc(CLK_HZ, SQE_DELAY_US);
    localparam int unsigned WID_CYC  = us_to_cyc(CLK_HZ, SQE_WIDTH_US);
    localparam int unsigned JMAX     = (JAB_CYC > IDLE_CYC) ? JAB_CYC : IDLE_CYC;
    localparam int unsigned SMAX     = (DLY_CYC > WID_CYC) ? DLY_CYC : WID_CYC;
    localparam int unsigned JCW      = $clog2(JMAX + 1);
    localparam int unsigned SCW      = $clog2(SMAX + 1);

    logic jabbed, frame_done, jab_entry, hb;
    logic stat_q;

    tjs_jabber_fsm #(.JAB_CYC(JAB_CYC), .IDLE_CYC(IDLE_CYC), .CW(JCW)) u_jab (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en_i      (tx_en_i),
        .jab_en_i     (jab_en_i),
        .jabbed_o     (jabbed),
        .frame_done_o (frame_done),
        .jab_entry_o  (jab_entry)
    );

    tjs_sqe_fsm #(.DLY_CYC(DLY_CYC), .WID_CYC(WID_CYC), .CW(SCW)) u_sqe (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done_i (frame_done),
        .tp_mode_i    (tp_mode_i),
        .sqe_dis_i    (sqe_dis_i),
        .hb_o         (hb)
    );

    // sticky status: entry wins over a same-cycle read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         stat_q <= 1'b0;
        else if (jab_entry) stat_q <= 1'b1;
        else if (stat_rd_i) stat_q <= 1'b0;
    end

    always_comb begin
        tx_en_o    = tx_en_i & ~jabbed;
        jab_stat_o = stat_q;
        col_o      = hb | line_col_i;
    end

    AST_STAT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jabbed) |-> jab_stat_o);  // R7
    AST_NO_HB_WHEN_JABBED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(jabbed) && !tx_en_i) |-> !hb);  // R10
endmodule

// File: tb/tjs_supervisor_tb.sv
module tjs_supervisor_tb;
    localparam int unsigned CLK_HZ  = 4_000_000;
    localparam int unsigned JAB_US  = 50;
    localparam int unsigned IDLE_US = 100;
    localparam int unsigned DLY_US  = 1;
    localparam int unsigned WID_US  = 1;
    localparam int J = (CLK_HZ / 1_000_000) * JAB_US;
    localparam int I = (CLK_HZ / 1_000_000) * IDLE_US;
    localparam int D = (CLK_HZ / 1_000_000) * DLY_US;
    localparam int W = (CLK_HZ / 1_000_000) * WID_US;
    localparam time CLK_PERIOD = 250ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, jab_en = 1'b1, sqe_dis = 1'b0, tp_mode = 1'b1, line_col = 1'b0, stat_rd = 1'b0;
    logic tx_en_o, jab_stat_o, col_o;
    int   n_tests = 0;
    int   n_fail = 0;
    int unsigned seed_init;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tjs_supervisor #(
        .CLK_HZ(CLK_HZ), .JAB_LIMIT_US(JAB_US), .UNJAB_IDLE_US(IDLE_US),
        .SQE_DELAY_US(DLY_US), .SQE_WIDTH_US(WID_US)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .jab_en_i(jab_en),
        .sqe_dis_i(sqe_dis), .tp_mode_i(tp_mode), .line_col_i(line_col),
        .stat_rd_i(stat_rd), .tx_en_o(tx_en_o), .jab_stat_o(jab_stat_o), .col_o(col_o)
    );

    function automatic bit exp_cut(int len, bit jen);
        return jen && (len > J);
    endfunction

    function automatic bit exp_hb(int len, bit jen, bit dis, bit tp);
        return tp && !dis && !exp_cut(len, jen);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic clear_stat();
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
    endtask

    task automatic run_frame(int len, bit jen, bit dis, bit tp);
        int  bad_gate = 0;
        int  bad_hb = 0;
        bit  cut = exp_cut(len, jen);
        bit  hbx = exp_hb(len, jen, dis, tp);
        jab_en = jen; sqe_dis = dis; tp_mode = tp;
        tx_en = 1'b1;
        for (int k = 0; k < len; k++) begin
            tick();
            if (tx_en_o !== !(jen && k >= J)) bad_gate++;
        end
        // R2 R3 R4: gate follows tx_en_i until the limit edge
        chk(bad_gate == 0, jen ? "R3 gate" : "R4 no cut", bad_gate, 0);
        tx_en = 1'b0;
        for (int m = 0; m < D + W + 3; m++) begin
            tick();
            if (col_o !== (hbx && m >= D && m < D + W)) bad_hb++;
        end
        // R8 R9 R10: heartbeat window
        chk(bad_hb == 0, cut ? "R10 hb" : (hbx ? "R8 hb" : "R9 hb"), bad_hb, 0);
        chk(jab_stat_o === cut, "R7 status", jab_stat_o, cut);
        clear_stat();
        chk(jab_stat_o === 1'b0, "R7 clear", jab_stat_o, 0);
        if (cut) ticks(I + 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        seed_init = $urandom(32'd2024);
        // R1: reset state
        ticks(3);
        chk(jab_stat_o === 1'b0 && tx_en_o === 1'b0 && col_o === 1'b0, "R1 reset", jab_stat_o, 0);
        rst_n = 1'b1;
        tick();
        line_col = 1'b1; #1;
        chk(col_o === 1'b1, "R1 col follows", col_o, 1);
        line_col = 1'b0;
        tick();

        // directed boundaries
        run_frame(J, 1, 0, 1);        // R3 longest passing frame, R8 heartbeat
        run_frame(J + 1, 1, 0, 1);    // R3 cut, R10 no heartbeat
        run_frame(J + 40, 0, 0, 1);   // R4 jabber disabled
        run_frame(12, 1, 1, 1);       // R9 disable bit
        run_frame(12, 1, 0, 0);       // R9 phone-line mode

        // R5: exact release boundary
        jab_en = 1'b1; tp_mode = 1'b1; sqe_dis = 1'b0;
        tx_en = 1'b1; ticks(J + 5);
        chk(tx_en_o === 1'b0, "R3 blocked", tx_en_o, 0);
        tx_en = 1'b0; ticks(I);
        chk(jab_stat_o === 1'b1, "R7 sticky", jab_stat_o, 1);
        tx_en = 1'b1; #1;
        chk(tx_en_o === 1'b0, "R5 still blocked at IDLE", tx_en_o, 0);
        tick();
        tx_en = 1'b0; ticks(I + 1);
        tx_en = 1'b1; #1;
        chk(tx_en_o === 1'b1, "R5 released at IDLE+1", tx_en_o, 1);
        ticks(3); tx_en = 1'b0; ticks(D + W + 4);
        clear_stat();

        // R6: countdown restart
        tx_en = 1'b1; ticks(J + 5);
        tx_en = 1'b0; ticks(I - 100);
        tx_en = 1'b1; ticks(3);
        chk(tx_en_o === 1'b0, "R6 reassert blocked", tx_en_o, 0);
        tx_en = 1'b0; ticks(I - 50);
        tx_en = 1'b1; #1;
        chk(tx_en_o === 1'b0, "R6 restarted", tx_en_o, 0);
        tick(); tx_en = 1'b0; ticks(I + 2);
        tx_en = 1'b1; #1;
        chk(tx_en_o === 1'b1, "R2 after release", tx_en_o, 1);
        ticks(2); tx_en = 1'b0; ticks(D + W + 4);
        clear_stat();

        // R11: line collision ORed during heartbeat window
        jab_en = 1'b1; tx_en = 1'b1; ticks(5);
        tx_en = 1'b0; line_col = 1'b1;
        begin
            int bad = 0;
            for (int m = 0; m < D + W + 2; m++) begin
                tick();
                if (col_o !== 1'b1) bad++;
            end
            chk(bad == 0, "R11 or", bad, 0);
        end
        line_col = 1'b0; #1;
        chk(col_o === 1'b0, "R11 idle low", col_o, 0);
        tick();

        // constrained random frames
        for (int f = 0; f < 30; f++) begin
            int  len;
            bit  jen, dis, tp;
            len = (($urandom % 4) == 0) ? (J - 6 + int'($urandom % 14)) : (1 + int'($urandom % 60));
            jen = ($urandom % 5) != 0;
            dis = ($urandom % 4) == 0;
            tp  = ($urandom % 4) != 0;
            run_frame(len, jen, dis, tp);
            ticks(int'($urandom % 8));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule